// File: doc/BRIEF.md
# Bloom Signature Conflict Detector

This block tracks which memory blocks one hardware-assisted transaction has touched. It keeps them in two Bloom-filter signatures held apart from any cache: one for the blocks the transaction has read and one for the blocks it has written. Transaction software adds each accessed block address through an explicit insert port. Nothing is added implicitly, so a cache eviction, whether from capacity or from a set conflict, leaves both signatures as they were.

A snoop port carries the block addresses of coherence requests from other agents. A request for exclusive ownership is a remote write, so it is tested against both signatures. A shared request is a remote read, so it is tested against the write signature only. One cycle after each snoop the block reports whether the address may belong to either set. Because of aliasing a hit can be false; a miss is always true. A clear input empties both signatures in one cycle when the transaction commits or aborts.

Each signature holds `SIG_BITS` bits and uses two index functions of the block address. Both functions cut the block address, zero-padded at the top, into chunks of log2(`SIG_BITS`) bits, counted from bit 0 as chunk 0.
- Index A is the XOR of all chunks.
- Index B is the XOR of the chunks after each chunk k has been rotated left by (k+1) mod log2(`SIG_BITS`) bit positions.

Inserting an address sets the bit at index A and the bit at index B. A lookup hits only if both of those bits are set.

Top module: `sig_conflict_detector`

## Requirements
- R1: After reset both signatures are empty: every snoop reports no hit, and all result outputs are low until the first snoop result.
- R2: An insert sets signature bits at index A and index B of `ins_blk`. The bits go into the write signature when `ins_is_write` is 1 and into the read signature when it is 0. The new bits are visible to a snoop presented in the next cycle or later.
- R3: A snoop with `snp_excl`=1 tests both signatures. `conflict_rd` reports a read-signature hit and `conflict_wr` reports a write-signature hit; both can be set at once.
- R4: A snoop with `snp_excl`=0 tests only the write signature. Its `conflict_rd` is always 0.
- R5: `res_valid` is high in exactly the cycle after `snp_valid` was high. `conflict` equals the OR of `conflict_rd` and `conflict_wr`. All three hit outputs are 0 whenever `res_valid` is 0.
- R6: A cycle with `clear`=1 empties both signatures by the next cycle. An insert in the same cycle as `clear` is discarded.
- R7: A snoop sees the signatures as they stood before any insert or clear in the same cycle.
- R8: An address that was never inserted hits whenever its index-A bit and its index-B bit are both set by other inserts. Such a false conflict is reported like a true one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_is_write | input | 1 | 1: insert into the write signature, 0: into the read signature |
| ins_blk | input | BLK_W | Physical block address to insert |
| snp_valid | input | 1 | Coherence snoop present |
| snp_excl | input | 1 | 1: exclusive (remote write) request, 0: shared request |
| snp_blk | input | BLK_W | Physical block address of the snoop |
| clear | input | 1 | Empty both signatures |
| res_valid | output | 1 | Snoop result strobe, one cycle after the snoop |
| conflict | output | 1 | Possible conflict with the transaction |
| conflict_rd | output | 1 | Snoop hit the read signature |
| conflict_wr | output | 1 | Snoop hit the write signature |

## Verification
The assertions check the timing rules on every cycle:
- the result strobe follows the snoop by exactly one cycle and is silent otherwise;
- a shared snoop never flags the read set;
- a snoop in the cycle after a clear finds nothing;
- an address inserted in one cycle hits a matching snoop in the next.

The hash functions themselves, the same-cycle ordering of snoop against insert, and false conflicts through aliasing can only be shown by the bench's scenarios. These run against a bit-level reference model that is compared on every clock.

// File: rtl/sig_conflict_detector.sv
module sig_conflict_detector #(
  parameter int BLK_W    = 34,
  parameter int SIG_BITS = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic             ins_is_write,
  input  logic [BLK_W-1:0] ins_blk,
  input  logic             snp_valid,
  input  logic             snp_excl,
  input  logic [BLK_W-1:0] snp_blk,
  input  logic             clear,
  output logic             res_valid,
  output logic             conflict,
  output logic             conflict_rd,
  output logic             conflict_wr
);
  localparam int IDX_W  = $clog2(SIG_BITS);
  localparam int NCHUNK = (BLK_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  function automatic logic [IDX_W-1:0] rotl(input logic [IDX_W-1:0] c, input int r);
    logic [2*IDX_W-1:0] d;
    d = {c, c} << r;
    return d[2*IDX_W-1 -: IDX_W];
  endfunction

  function automatic logic [2*IDX_W-1:0] hash_pair(input logic [BLK_W-1:0] b);
    logic [PAD_W-1:0] p;
    logic [IDX_W-1:0] ha, hb, c;
    p = '0;
    p[BLK_W-1:0] = b;
    ha = '0;
    hb = '0;
    for (int k = 0; k < NCHUNK; k++) begin
      c  = p[k*IDX_W +: IDX_W];
      ha = ha ^ c;
      hb = hb ^ rotl(c, (k + 1) % IDX_W);
    end
    return {hb, ha};
  endfunction

  logic [SIG_BITS-1:0] rd_sig, wr_sig;
  logic [IDX_W-1:0]    ia, ib, sa, sb;
  logic                rd_hit, wr_hit;
  logic                hit_rd_q, hit_wr_q, vld_q;

  assign {ib, ia} = hash_pair(ins_blk);
  assign {sb, sa} = hash_pair(snp_blk);

  assign rd_hit = snp_excl & rd_sig[sa] & rd_sig[sb];
  assign wr_hit = wr_sig[sa] & wr_sig[sb];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_sig <= '0;
      wr_sig <= '0;
    end else if (ins_valid) begin
      if (ins_is_write) begin
        wr_sig[ia] <= 1'b1;
        wr_sig[ib] <= 1'b1;
      end else begin
        rd_sig[ia] <= 1'b1;
        rd_sig[ib] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      hit_rd_q <= 1'b0;
      hit_wr_q <= 1'b0;
    end else begin
      vld_q    <= snp_valid;
      hit_rd_q <= snp_valid & rd_hit;
      hit_wr_q <= snp_valid & wr_hit;
    end
  end

  assign res_valid   = vld_q;
  assign conflict_rd = hit_rd_q;
  assign conflict_wr = hit_wr_q;
  assign conflict    = hit_rd_q | hit_wr_q;
endmodule

// File: rtl/sig_conflict_checker.sv
module sig_conflict_checker #(
  parameter int BLK_W = 34
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ins_is_write,
  input logic [BLK_W-1:0] ins_blk,
  input logic             snp_valid,
  input logic             snp_excl,
  input logic [BLK_W-1:0] snp_blk,
  input logic             clear,
  input logic             res_valid,
  input logic             conflict,
  input logic             conflict_rd,
  input logic             conflict_wr
);
  // R5
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> res_valid);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |=> (!res_valid && !conflict && !conflict_rd && !conflict_wr));

  // R4
  shared_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_excl) |=> !conflict_rd);

  // R6
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear ##1 snp_valid) |=> !conflict);

  // R2
  wr_insert_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ins_valid && ins_is_write && !clear) ##1 (snp_valid && !clear && snp_blk == $past(ins_blk)))
    |=> conflict_wr);

  // R3
  rd_insert_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ins_valid && !ins_is_write && !clear) ##1 (snp_valid && snp_excl && snp_blk == $past(ins_blk)))
    |=> conflict_rd);
endmodule

bind sig_conflict_detector sig_conflict_checker #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_is_write(ins_is_write),
  .ins_blk(ins_blk), .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_blk(snp_blk),
  .clear(clear), .res_valid(res_valid), .conflict(conflict),
  .conflict_rd(conflict_rd), .conflict_wr(conflict_wr)
);

// File: tb/tb_sig_conflict_detector.sv
module tb_sig_conflict_detector;
  localparam int BW  = 34;
  localparam int SB  = 512;
  localparam int IW  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_is_write = 1'b0, snp_valid = 1'b0, snp_excl = 1'b0, clear = 1'b0;
  logic [BW-1:0] ins_blk = '0, snp_blk = '0;
  logic res_valid, conflict, conflict_rd, conflict_wr;

  sig_conflict_detector #(.BLK_W(BW), .SIG_BITS(SB)) dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_is_write(ins_is_write),
    .ins_blk(ins_blk), .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_blk(snp_blk),
    .clear(clear), .res_valid(res_valid), .conflict(conflict),
    .conflict_rd(conflict_rd), .conflict_wr(conflict_wr)
  );

  always #2 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  bit mrd [SB];
  bit mwr [SB];
  bit e_vld, e_rd, e_wr;

  function automatic int idx_a(input logic [BW-1:0] b);
    int h = 0;
    for (int i = 0; i < BW; i++) if (b[i]) h = h ^ (1 << (i % IW));
    return h;
  endfunction

  function automatic int idx_b(input logic [BW-1:0] b);
    int h = 0;
    for (int i = 0; i < BW; i++) if (b[i]) h = h ^ (1 << (((i % IW) + (i / IW) + 1) % IW));
    return h;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mrd[i]) begin mrd[i] = 0; mwr[i] = 0; end
      e_vld = 0; e_rd = 0; e_wr = 0;
    end else begin
      e_vld = snp_valid;
      e_rd  = snp_valid && snp_excl && mrd[idx_a(snp_blk)] && mrd[idx_b(snp_blk)];
      e_wr  = snp_valid && mwr[idx_a(snp_blk)] && mwr[idx_b(snp_blk)];
      if (clear) begin
        foreach (mrd[i]) begin mrd[i] = 0; mwr[i] = 0; end
      end else if (ins_valid) begin
        if (ins_is_write) begin mwr[idx_a(ins_blk)] = 1; mwr[idx_b(ins_blk)] = 1; end
        else begin mrd[idx_a(ins_blk)] = 1; mrd[idx_b(ins_blk)] = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      compared++;
      if (res_valid !== e_vld || conflict_rd !== e_rd || conflict_wr !== e_wr ||
          conflict !== (e_rd | e_wr)) begin
        mismatched++;
        $display("FAIL %s model: got v=%b r=%b w=%b c=%b expected v=%b r=%b w=%b c=%b",
                 cur_req, res_valid, conflict_rd, conflict_wr, conflict,
                 e_vld, e_rd, e_wr, e_rd | e_wr);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_ins(input logic [BW-1:0] b, input bit w);
    ins_valid = 1; ins_is_write = w; ins_blk = b;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic do_snp(input logic [BW-1:0] b, input bit x, output bit r, output bit w);
    snp_valid = 1; snp_excl = x; snp_blk = b;
    @(negedge clk);
    snp_valid = 0;
    r = conflict_rd; w = conflict_wr;
  endtask

  task automatic do_clear();
    clear = 1;
    @(negedge clk);
    clear = 0;
  endtask

  logic [BW-1:0] a_blk, b_blk, c_blk;
  bit r, w;

  initial begin
    #400000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    chk(res_valid == 0 && conflict == 0, "R1 reset outputs", conflict, 0);
    do_snp(34'h12345, 1, r, w);
    chk(!r && !w, "R1 empty after reset", r | w, 0);

    cur_req = "R3";
    a_blk = 34'h2_0000_0ABC;
    do_ins(a_blk, 0);
    do_snp(a_blk, 1, r, w);
    chk(r == 1, "R3 excl hits read set", r, 1);
    chk(w == 0, "R3 read insert not in write set", w, 0);
    cur_req = "R4";
    do_snp(a_blk, 0, r, w);
    chk(r == 0 && w == 0, "R4 shared ignores read set", r | w, 0);

    cur_req = "R2";
    b_blk = 34'h1_2345_6789;
    do_ins(b_blk, 1);
    do_snp(b_blk, 0, r, w);
    chk(w == 1, "R2 write insert visible", w, 1);
    do_snp(b_blk, 1, r, w);
    chk(w == 1, "R3 excl hits write set", w, 1);

    cur_req = "R7";
    c_blk = 34'h0_0F0F_F0F0;
    ins_valid = 1; ins_is_write = 1; ins_blk = c_blk;
    snp_valid = 1; snp_excl = 1; snp_blk = c_blk;
    @(negedge clk);
    ins_valid = 0; snp_valid = 0;
    chk(conflict_wr == 0, "R7 same-cycle snoop sees old set", conflict_wr, 0);
    do_snp(c_blk, 1, r, w);
    chk(w == 1, "R7 insert visible next cycle", w, 1);

    cur_req = "R6";
    ins_valid = 1; ins_is_write = 0; ins_blk = 34'h3_3333_3333;
    clear = 1;
    @(negedge clk);
    ins_valid = 0; clear = 0;
    do_snp(a_blk, 1, r, w);
    chk(!r && !w, "R6 cleared read set", r | w, 0);
    do_snp(b_blk, 1, r, w);
    chk(!r && !w, "R6 cleared write set", r | w, 0);
    do_snp(34'h3_3333_3333, 1, r, w);
    chk(!r && !w, "R6 clear beats insert", r | w, 0);

    cur_req = "R8";
    c_blk = 34'h2_A5A5_5A5A;
    a_blk = c_blk ^ 34'h201;
    b_blk = c_blk ^ 34'h202;
    chk(idx_a(a_blk) == idx_a(c_blk), "R8 alias setup A", idx_a(a_blk), idx_a(c_blk));
    chk(idx_b(b_blk) == idx_b(c_blk), "R8 alias setup B", idx_b(b_blk), idx_b(c_blk));
    do_ins(a_blk, 0);
    do_ins(b_blk, 0);
    do_snp(c_blk, 1, r, w);
    chk(r == 1, "R8 false conflict reported", r, 1);
    do_clear();

    cur_req = "R5";
    for (int n = 0; n < 3000; n++) begin
      logic [BW-1:0] pick;
      pick = {$urandom, $urandom};
      if ($urandom_range(0, 2) != 0) pick = BW'($urandom_range(0, 15) * 34'h1_0000_0041);
      ins_valid    = ($urandom_range(0, 3) == 0);
      ins_is_write = $urandom_range(0, 1);
      ins_blk      = pick;
      snp_valid    = ($urandom_range(0, 1) == 0);
      snp_excl     = $urandom_range(0, 1);
      snp_blk      = BW'($urandom_range(0, 15) * 34'h1_0000_0041);
      clear        = ($urandom_range(0, 199) == 0);
      @(negedge clk);
    end
    ins_valid = 0; snp_valid = 0; clear = 0;
    @(negedge clk);
    @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule